// File: doc/BRIEF.md
# HDQ Single-Wire Bus Master

This block runs transactions on an HDQ single-wire bus, the kind battery fuel gauges use, as the master. All protocol timing follows a sample tick (nominally one every 20 us) that the surrounding chip supplies. Every duration is a parameter counted in ticks. A host pulses `start_i` with a 7-bit register address, a direction flag and, for writes, one data byte. The block sends a break and a recovery gap. It then transmits the command byte and either transmits the data byte or receives one byte from the slave. It finishes with a one-cycle `done_o` pulse and a 2-bit status code.

The wire is open-drain. `oe_o` means the master owns the line. While it owns the line, `drv_low_o` pulls the line low, and otherwise the master drives it high. When `oe_o` is low an external pull-up holds the line high. The input passes through a two-flop synchronizer. Slave bits are decoded from the length of each low pulse, counted in ticks.

Top module: `hdq_master`

## Requirements
- R1: The line controls `oe_o` and `drv_low_o` change only on a clock cycle where `tick_i` is high.
- R2: A transaction begins on the first tick after an accepted start. The line is held low for 10 ticks (the break) and then driven high for 3 ticks (recovery). The first command cell therefore starts 13 ticks after the break starts.
- R3: The command byte is `{wr_i, addr_i[6:0]}`, with bit 7 = 1 for a write and 0 for a read. It is sent least significant bit first.
- R4: Every transmitted cell lasts 10 ticks. A '1' is a 2-tick low pulse and a '0' is a 6-tick low pulse, and the line is driven high for the rest of the cell. Within a byte, consecutive cells start exactly 10 ticks apart.
- R5: For a write, the command byte is followed by 15 high ticks, then the data byte (same encoding), then 15 more high ticks. `done_o` then pulses with `err_o` = 0. The whole transaction lasts exactly 203 ticks from the start of the break.
- R6: For a read, the line is released (`oe_o` = 0) at the end of the command byte. If no low level is sampled within 150 ticks, the transaction ends with `err_o` = 1 exactly 150 ticks after the release. A low level first sampled on the 150th tick is still accepted.
- R7: Each received bit is decoded from its low time in ticks. A low time of 3 ticks or fewer gives '1', and 4 or more gives '0'. Bits enter at bit 7 of the receive register and shift right, so the first bit received ends up as bit 0. After 8 bits, `rdata_o` is updated and `done_o` pulses with `err_o` = 0.
- R8: A received low pulse that stays low on 15 ticks after its first low sample aborts with `err_o` = 2. A high gap between received bits lasting 20 ticks aborts with `err_o` = 3. On any error `rdata_o` keeps its previous value.
- R9: When idle, `oe_o` = 0. `done_o` is a single-cycle pulse, given once per transaction. A start pulse that arrives while a transaction is pending or running is ignored.
- R10: After reset, `oe_o`, `drv_low_o`, `done_o`, `err_o` and `rdata_o` are all zero. `err_o` and `rdata_o` change only in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample tick that paces all protocol timing |
| start_i | input | 1 | Request a transaction; accepted only when idle |
| addr_i | input | 7 | Slave register address |
| wr_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 8 | Byte to write |
| rdata_o | output | 8 | Last byte read successfully |
| err_o | output | 2 | 0 ok, 1 no response, 2 low too long, 3 high gap too long |
| done_o | output | 1 | One-cycle completion pulse |
| line_i | input | 1 | Raw level of the bus line |
| oe_o | output | 1 | Master drives the line |
| drv_low_o | output | 1 | When driving, pull low (else drive high) |

## Verification
On every cycle, the assertions check that the line controls move only on tick cycles and that the line is released whenever the block is idle or receiving. They also check that the done pulse lasts one cycle and comes only on return to idle, that status and read data change only with done, and that the receive bit count stays in range. The bench is the only place that checks the waveform itself. It measures the break, recovery, cell spacing and low-pulse widths in clock cycles and decodes the command and data bytes from them. The bench also covers the exact transaction lengths, the 3-tick/4-tick decode threshold, the 150-tick response window at its edge, and each error code from a scripted slave.

// File: rtl/hdq_pkg.sv
package hdq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_BREAK, S_RECOV, S_TXLO, S_TXHI, S_GAP, S_RXWAIT, S_RXLO, S_RXHI
  } hdq_state_t;

  localparam logic [1:0] ERR_OK      = 2'd0;
  localparam logic [1:0] ERR_NO_RESP = 2'd1;
  localparam logic [1:0] ERR_LOW_TMO = 2'd2;
  localparam logic [1:0] ERR_GAP_TMO = 2'd3;

  // low phase length of a transmitted cell, in ticks
  function automatic int unsigned cell_low(input logic b,
                                           input int unsigned one_t,
                                           input int unsigned zero_t);
    return b ? one_t : zero_t;
  endfunction

  // high remainder so that low + high equals the cell length
  function automatic int unsigned cell_high(input logic b,
                                            input int unsigned cell_t,
                                            input int unsigned one_t,
                                            input int unsigned zero_t);
    return cell_t - cell_low(b, one_t, zero_t);
  endfunction

  // pulse-width decision for a received bit
  function automatic logic rx_decide(input int unsigned low_t,
                                     input int unsigned one_max);
    return low_t <= one_max;
  endfunction

endpackage

// File: rtl/hdq_sync.sv
module hdq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hdq_rx_shift.sv
module hdq_rx_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] sh_q;

  assign next_o = {bit_i, sh_q[WIDTH-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= next_o;
  end
endmodule

// File: rtl/hdq_master.sv
module hdq_master
  import hdq_pkg::*;
#(
  parameter int unsigned T_BREAK   = 10,
  parameter int unsigned T_RECOV   = 3,
  parameter int unsigned T_CELL    = 10,
  parameter int unsigned T_ONE     = 2,
  parameter int unsigned T_ZERO    = 6,
  parameter int unsigned T_GAP     = 15,
  parameter int unsigned T_RXWAIT  = 150,
  parameter int unsigned T_RXLOW   = 15,
  parameter int unsigned T_RXHIGH  = 20,
  parameter int unsigned T_ONE_MAX = 3,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [1:0]        err_o,
  output logic              done_o,
  input  logic              line_i,
  output logic              oe_o,
  output logic              drv_low_o
);
  localparam int unsigned CW = $clog2(T_RXWAIT + 2);
  localparam int unsigned BYTE_W = ADDR_W + 1;

  hdq_state_t        st_q;
  logic [CW-1:0]     cnt_q, lowcnt_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [7:0]        wdat_q, shf_q;
  logic [3:0]        nbit_q;
  logic              pend_q, dphase_q;

  // named internal events for the checker
  logic line_s, busy_w, rx_phase_w, last_w, accept_w, rx_shift_w, rx_bit_w;
  logic [7:0] rx_next_w;

  assign busy_w     = (st_q != S_IDLE);
  assign rx_phase_w = (st_q == S_RXWAIT) || (st_q == S_RXLO) || (st_q == S_RXHI);
  assign last_w     = (cnt_q == CW'(1));
  assign accept_w   = start_i && !busy_w && !pend_q;
  assign rx_bit_w   = rx_decide(32'(lowcnt_q), T_ONE_MAX);
  assign rx_shift_w = tick_i && (st_q == S_RXLO) && line_s;

  hdq_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  hdq_rx_shift #(.WIDTH(8)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(rx_shift_w),
    .bit_i(rx_bit_w), .next_o(rx_next_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      lowcnt_q  <= '0;
      cmd_q     <= '0;
      wdat_q    <= '0;
      shf_q     <= '0;
      nbit_q    <= '0;
      pend_q    <= 1'b0;
      dphase_q  <= 1'b0;
      oe_o      <= 1'b0;
      drv_low_o <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= ERR_OK;
      rdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_w) begin
        pend_q <= 1'b1;
        cmd_q  <= {wr_i, addr_i};
        wdat_q <= wdata_i;
      end
      if (tick_i) begin
        unique case (st_q)
          S_IDLE: if (pend_q) begin
            pend_q    <= 1'b0;
            st_q      <= S_BREAK;
            cnt_q     <= CW'(T_BREAK);
            oe_o      <= 1'b1;
            drv_low_o <= 1'b1;
          end
          S_BREAK: if (last_w) begin
            st_q      <= S_RECOV;
            cnt_q     <= CW'(T_RECOV);
            drv_low_o <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
          S_RECOV: if (last_w) begin
            shf_q     <= 8'(cmd_q);
            nbit_q    <= 4'd8;
            dphase_q  <= 1'b0;
            st_q      <= S_TXLO;
            cnt_q     <= CW'(cell_low(cmd_q[0], T_ONE, T_ZERO));
            drv_low_o <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
          S_TXLO: if (last_w) begin
            st_q      <= S_TXHI;
            cnt_q     <= CW'(cell_high(shf_q[0], T_CELL, T_ONE, T_ZERO));
            drv_low_o <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
          S_TXHI: if (last_w) begin
            shf_q  <= shf_q >> 1;
            nbit_q <= nbit_q - 1'b1;
            if (nbit_q != 4'd1) begin
              st_q      <= S_TXLO;
              cnt_q     <= CW'(cell_low(shf_q[1], T_ONE, T_ZERO));
              drv_low_o <= 1'b1;
            end else if (!dphase_q && !cmd_q[BYTE_W-1]) begin
              st_q  <= S_RXWAIT;
              cnt_q <= CW'(T_RXWAIT);
              oe_o  <= 1'b0;
            end else begin
              st_q  <= S_GAP;
              cnt_q <= CW'(T_GAP);
            end
          end else cnt_q <= cnt_q - 1'b1;
          S_GAP: if (last_w) begin
            if (!dphase_q) begin
              dphase_q  <= 1'b1;
              shf_q     <= wdat_q;
              nbit_q    <= 4'd8;
              st_q      <= S_TXLO;
              cnt_q     <= CW'(cell_low(wdat_q[0], T_ONE, T_ZERO));
              drv_low_o <= 1'b1;
            end else begin
              st_q   <= S_IDLE;
              oe_o   <= 1'b0;
              done_o <= 1'b1;
              err_o  <= ERR_OK;
            end
          end else cnt_q <= cnt_q - 1'b1;
          S_RXWAIT: if (!line_s) begin
            st_q     <= S_RXLO;
            lowcnt_q <= CW'(1);
            cnt_q    <= CW'(T_RXLOW);
            nbit_q   <= 4'd8;
          end else if (last_w) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= ERR_NO_RESP;
          end else cnt_q <= cnt_q - 1'b1;
          S_RXLO: if (line_s) begin
            nbit_q <= nbit_q - 1'b1;
            if (nbit_q == 4'd1) begin
              st_q    <= S_IDLE;
              done_o  <= 1'b1;
              err_o   <= ERR_OK;
              rdata_o <= rx_next_w;
            end else begin
              st_q  <= S_RXHI;
              cnt_q <= CW'(T_RXHIGH);
            end
          end else begin
            lowcnt_q <= lowcnt_q + 1'b1;
            if (last_w) begin
              st_q   <= S_IDLE;
              done_o <= 1'b1;
              err_o  <= ERR_LOW_TMO;
            end else cnt_q <= cnt_q - 1'b1;
          end
          S_RXHI: if (!line_s) begin
            st_q     <= S_RXLO;
            lowcnt_q <= CW'(1);
            cnt_q    <= CW'(T_RXLOW);
          end else if (last_w) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= ERR_GAP_TMO;
          end else cnt_q <= cnt_q - 1'b1;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdq_master_chk.sv
module hdq_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       oe_o,
  input logic       drv_low_o,
  input logic       done_o,
  input logic [1:0] err_o,
  input logic [7:0] rdata_o,
  input logic       busy_w,
  input logic       rx_phase_w,
  input logic [3:0] nbit_q
);
  a_r1_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(oe_o) && $stable(drv_low_o)));

  a_r4_low_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_low_o |-> oe_o);

  a_r6_rx_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_phase_w |-> !oe_o);

  a_r9_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_w |-> !oe_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_w);

  a_r10_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(err_o)));

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(rdata_o)));

  a_r7_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbit_q <= 4'd8);
endmodule

bind hdq_master hdq_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .oe_o(oe_o),
  .drv_low_o(drv_low_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .busy_w(busy_w), .rx_phase_w(rx_phase_w), .nbit_q(nbit_q)
);

// File: tb/hdq_master_tb.sv
`timescale 1ns/1ps
module hdq_master_tb;
  localparam int TK = 4;  // clocks per tick

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, wr = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] err;
  logic done, oe, drv_low, slave_low = 1'b0;
  wire  line = !((oe && drv_low) || slave_low);

  hdq_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .err_o(err), .done_o(done), .line_i(line), .oe_o(oe), .drv_low_o(drv_low)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, np = 0, dcount = 0, done_cyc = 0, oe_fall = 0;
  int pst[40], pw[40];
  logic mlow_q = 1'b0, oe_q = 1'b0;
  logic [7:0] last_good = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (TK - 1) @(posedge clk);
    #1 tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
  end

  always @(negedge clk) begin
    logic ml;
    ml = oe && drv_low;
    if (ml && !mlow_q && np < 40) pst[np] = cyc;
    if (!ml && mlow_q) begin
      if (np < 40) pw[np] = cyc - pst[np];
      np++;
    end
    if (oe_q && !oe) oe_fall = cyc;
    if (done) begin dcount++; done_cyc = cyc; end
    mlow_q = ml;
    oe_q = oe;
  end

  initial begin
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog: act=%0d exp=<190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_w(input logic b);
    return b ? 2 * TK : 6 * TK;
  endfunction

  function automatic int decode(input int base);
    int v = 0;
    for (int i = 0; i < 8; i++) begin
      if (pw[base + i] == exp_w(1'b1)) v |= (1 << i);
      else if (pw[base + i] != exp_w(1'b0)) v |= 256;
    end
    return v;
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic kick(input logic w, input logic [6:0] a, input logic [7:0] d);
    @(posedge clk);
    #1 start = 1'b1; wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int g = 0;
    while (dcount == d0 && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic check_cmd(input logic w, input logic [6:0] a);
    chk(pw[0] == 10 * TK, "R2 break width", pw[0], 10 * TK);
    chk(pst[1] - pst[0] == 13 * TK, "R2 break+recovery", pst[1] - pst[0], 13 * TK);
    chk(decode(1) == int'({w, a}), "R3 command byte", decode(1), int'({w, a}));
    for (int i = 1; i < 8; i++)
      if (pst[i + 1] - pst[i] != 10 * TK)
        chk(1'b0, "R4 cell spacing", pst[i + 1] - pst[i], 10 * TK);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d, input bit intrude);
    int d0 = dcount;
    np = 0;
    kick(1'b1, a, d);
    if (intrude) begin
      wait_ticks(50);
      kick(1'b0, ~a, ~d);
    end
    wait_done(d0);
    check_cmd(1'b1, a);
    chk(decode(9) == int'(d), "R5 data byte", decode(9), int'(d));
    chk(err == 2'd0, "R5 write status", err, 0);
    chk(done_cyc - pst[0] == 203 * TK, "R5 write length", done_cyc - pst[0], 203 * TK);
    if (intrude) begin
      wait_ticks(40);
      chk(np == 17, "R9 start ignored pulses", np, 17);
      chk(dcount == d0 + 1, "R9 single done", dcount - d0, 1);
    end
  endtask

  // mode 0 normal, 1 silent, 2 stuck low at bit k, 3 stop after k bits
  task automatic slave(input logic [7:0] b, input int dly, input int w1, input int w0,
                       input int hi, input int mode, input int k);
    @(negedge oe);
    if (mode == 1) return;
    wait_ticks(dly);
    for (int i = 0; i < 8; i++) begin
      if (mode == 3 && i == k) return;
      slave_low = 1'b1;
      if (mode == 2 && i == k) begin
        wait_ticks(30);
        slave_low = 1'b0;
        return;
      end
      wait_ticks(b[i] ? w1 : w0);
      slave_low = 1'b0;
      if (i != 7) wait_ticks(hi);
    end
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] b, input int dly,
                         input int w1, input int w0, input int hi,
                         input int mode, input int k, input string tag);
    int d0 = dcount;
    int ee;
    np = 0;
    ee = (mode == 0) ? 0 : mode;
    fork
      kick(1'b0, a, 8'h00);
      slave(b, dly, w1, w0, hi, mode, k);
      wait_done(d0);
    join
    check_cmd(1'b0, a);
    chk(np == 9, "R6 no master pulses after command", np, 9);
    chk(int'(err) == ee, {tag, " status"}, err, ee);
    if (mode == 0) last_good = b;
    chk(rdata == last_good, {tag, " read data"}, rdata, last_good);
    if (mode == 1)
      chk(done_cyc - oe_fall == 150 * TK, "R6 timeout instant", done_cyc - oe_fall, 150 * TK);
    wait_ticks(3);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (5) @(posedge clk);
    chk(oe == 1'b0 && drv_low == 1'b0, "R10 reset line", {oe, drv_low}, 0);
    chk(done == 1'b0 && err == 2'd0 && rdata == 8'h00, "R10 reset outputs", {done, err, rdata}, 0);
    #1 rst_n = 1'b1;
    wait_ticks(3);
    chk(oe == 1'b0, "R9 idle released", oe, 0);

    do_write(7'h55, 8'hA3, 1'b0);
    do_write(7'h00, 8'hFF, 1'b1);
    do_read(7'h12, 8'h6C, 4, 2, 6, 4, 0, 0, "R7 basic");
    do_read(7'h7F, 8'hA5, 2, 3, 4, 3, 0, 0, "R7 threshold");
    do_read(7'h21, 8'h3C, 149, 2, 6, 4, 0, 0, "R6 late edge");
    do_read(7'h33, 8'h00, 0, 2, 6, 4, 1, 0, "R6 silent");
    do_read(7'h44, 8'hF0, 3, 2, 6, 4, 2, 3, "R8 stuck low");
    do_read(7'h45, 8'h0F, 3, 2, 6, 4, 3, 5, "R8 gap timeout");

    for (int n = 0; n < 6; n++) begin
      logic [6:0] ra = 7'($urandom);
      logic [7:0] rd = 8'($urandom);
      if ($urandom % 2) do_write(ra, rd, 1'b0);
      else do_read(ra, rd, 1 + int'($urandom % 20), 1 + int'($urandom % 3),
                   4 + int'($urandom % 4), 2 + int'($urandom % 5), 0, 0, "R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule